// File: doc/BRIEF.md
# Edge Timestamp Capture with Circular DMA Writer

This block keeps a free-running counter on the internal clock and watches one external input. When the chosen transition of that input arrives, the block takes a snapshot of the counter and asks a DMA engine to move the snapshot into memory. The engine acknowledges each request. The block keeps the index of the next slot in a circular buffer of DEPTH words, so the engine writes the data word to that slot.

Software reads the buffer in halves. A pulse marks the moment the lower half becomes full, and a second pulse marks the moment the upper half becomes full. One half can then be processed while the other half fills. The time between two input pulses is the unsigned difference between adjacent entries, which stays correct across a counter wrap. If a second capture arrives before the engine has taken the first, a sticky overcapture flag is raised and the newer snapshot replaces the older one.

Top module: `pulse_timestamp_dma`

## Requirements
- R1: After reset the counter output, dma_req, ovr_flag, irq_half, irq_full and dma_index are all zero.
- R2: While cfg_enable is 1 the counter rises by exactly one per clock and wraps modulo 2^CNT_W. While cfg_enable is 0 it holds its value.
- R3: The input passes through a two-stage synchroniser. A captured value equals the counter output seen in the cycle in which the new input level is first applied, plus two.
- R4: cfg_falling = 0 selects the 0-to-1 transition and cfg_falling = 1 selects the 1-to-0 transition. The other transition causes no capture and no request.
- R5: A capture raises dma_req, which stays high until dma_ack is high at a clock edge. That edge completes one transfer of dma_data to slot dma_index.
- R6: dma_index starts at 0 and advances by one per completed transfer. After slot DEPTH-1 it returns to 0.
- R7: irq_half is a one-cycle pulse in the cycle after the transfer to slot DEPTH/2-1. irq_full is a one-cycle pulse in the cycle after the transfer to slot DEPTH-1. No pulse follows transfers to any other slot.
- R8: A capture while dma_req is pending and not acknowledged sets ovr_flag, and dma_data then holds the newer value. ovr_flag stays set until ovr_clr is 1 at a clock edge, which clears it.
- R9: While cfg_enable is 0, input transitions cause no capture and no request.
- R10: The unsigned difference between adjacent buffer entries equals the number of clock cycles between the matching input transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Runs the counter and enables capture |
| cfg_falling | input | 1 | Edge select: 0 rising, 1 falling |
| ovr_clr | input | 1 | Clears the overcapture flag |
| pin_in | input | 1 | Asynchronous external input |
| count_o | output | CNT_W | Current counter value |
| dma_req | output | 1 | Transfer request, held until acknowledged |
| dma_ack | input | 1 | Transfer acknowledge from the DMA engine |
| dma_data | output | CNT_W | Captured counter value to be written |
| dma_index | output | $clog2(DEPTH) | Buffer slot for the pending transfer |
| ovr_flag | output | 1 | Sticky overcapture indication |
| irq_half | output | 1 | Lower half of the buffer filled |
| irq_full | output | 1 | Upper half of the buffer filled |

## Verification
The bench drives a long train of random-width pulses in rising mode and then in falling mode. Each stored word is compared with the counter value read when its edge was driven, and the gap between adjacent words is compared with the bench's own cycle count. This separates latency errors from errors in the edge selection. Acknowledge delays are random, and the train runs past the half point and the wrap of the buffer, so misplaced notifications or a wrong wrap show up at particular slots. Directed sequences then withhold the acknowledge to force an overcapture, apply the opposite edge in each mode, and toggle the input while the block is disabled.

// File: rtl/pulse_timestamp_dma.sv
module pulse_timestamp_dma #(
  parameter int CNT_W = 32,
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_falling,
  input  logic             ovr_clr,
  input  logic             pin_in,
  output logic [CNT_W-1:0] count_o,
  output logic             dma_req,
  input  logic             dma_ack,
  output logic [CNT_W-1:0] dma_data,
  output logic [IDX_W-1:0] dma_index,
  output logic             ovr_flag,
  output logic             irq_half,
  output logic             irq_full
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] MID_IDX  = IDX_W'(HALF - 1);

  logic [2:0] sync_q;
  logic       cap_ev, xfer;

  assign cap_ev = cfg_enable && (cfg_falling ? (sync_q[2] && !sync_q[1])
                                             : (sync_q[1] && !sync_q[2]));
  assign xfer = dma_req && dma_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      count_o <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_in};
      if (cfg_enable) count_o <= count_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_data <= '0;
      dma_req  <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (cap_ev) dma_data <= count_o;
      dma_req <= cap_ev || (dma_req && !dma_ack);
      if (cap_ev && dma_req && !dma_ack) ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_index <= '0;
      irq_half  <= 1'b0;
      irq_full  <= 1'b0;
    end else begin
      irq_half <= xfer && (dma_index == MID_IDX);
      irq_full <= xfer && (dma_index == LAST_IDX);
      if (xfer) dma_index <= (dma_index == LAST_IDX) ? '0 : dma_index + 1'b1;
    end
  end

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> $stable(count_o));

  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> (dma_index == (($past(dma_index) == LAST_IDX) ? '0
                                            : IDX_W'($past(dma_index) + 1'b1))));

  p_idx_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && dma_ack) |=> $stable(dma_index));

  p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_half && irq_full));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  p_no_cap_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !dma_req) |=> !dma_req);
endmodule

// File: tb/pulse_timestamp_dma_tb.sv
module pulse_timestamp_dma_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 32;
  localparam int DEPTH = 128;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_falling = 1'b0, ovr_clr = 1'b0, pin_in = 1'b0;
  logic dma_ack = 1'b0;
  logic [CNT_W-1:0] count_o, dma_data;
  logic [IDX_W-1:0] dma_index;
  logic dma_req, ovr_flag, irq_half, irq_full;

  pulse_timestamp_dma #(.CNT_W(CNT_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_falling(cfg_falling),
    .ovr_clr(ovr_clr), .pin_in(pin_in), .count_o(count_o), .dma_req(dma_req),
    .dma_ack(dma_ack), .dma_data(dma_data), .dma_index(dma_index),
    .ovr_flag(ovr_flag), .irq_half(irq_half), .irq_full(irq_full));

  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int unsigned cyc = 0;
  logic [CNT_W-1:0] exp_val [0:511];
  int unsigned exp_cyc [0:511];
  int n_exp = 0, n_xfer = 0;
  logic dma_auto = 1'b0, man_ack = 1'b0;
  logic prev_acked = 1'b0;
  logic [IDX_W-1:0] prev_idx = '0;
  logic [CNT_W-1:0] prev_data = '0;
  int wait_n = 0, n_half = 0, n_full = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  function automatic logic [CNT_W-1:0] gap(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return a - b;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_half == (prev_acked && prev_idx == IDX_W'(DEPTH/2-1)), "R7 irq_half", irq_half, !irq_half);
      chk(irq_full == (prev_acked && prev_idx == IDX_W'(DEPTH-1)), "R7 irq_full", irq_full, !irq_full);
      if (irq_half) n_half++;
      if (irq_full) n_full++;
    end
    prev_acked = 1'b0;
    if (dma_auto && dma_req && (wait_n >= 2 || ($urandom % 2) == 1)) begin
      chk(dma_index == IDX_W'(n_xfer % DEPTH), "R6 slot", dma_index, n_xfer % DEPTH);
      chk(dma_data == exp_val[n_xfer], "R3 R5 word", dma_data, exp_val[n_xfer]);
      if (n_xfer > 0)
        chk(gap(dma_data, prev_data) == CNT_W'(exp_cyc[n_xfer] - exp_cyc[n_xfer-1]),
            "R10 gap", gap(dma_data, prev_data), exp_cyc[n_xfer] - exp_cyc[n_xfer-1]);
      prev_data = dma_data;
      prev_idx = dma_index;
      prev_acked = 1'b1;
      n_xfer++;
      wait_n = 0;
      dma_ack = 1'b1;
    end else begin
      if (dma_auto && dma_req) wait_n++;
      dma_ack = man_ack;
    end
  end

  task automatic drive(input logic v, input bit record);
    @(negedge clk);
    if (record) begin
      exp_val[n_exp] = count_o + 2;
      exp_cyc[n_exp] = cyc;
      n_exp++;
    end
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] c0, c2;
    void'($urandom(32'h5eed_1234));
    idle(3);
    chk(count_o == 0 && !dma_req && !ovr_flag && !irq_half && !irq_full && dma_index == 0,
        "R1 reset", {count_o, dma_req}, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    chk(count_o == 0 && !dma_req && dma_index == 0, "R1 after release", count_o, 0);

    cfg_enable = 1'b1;
    idle(1);
    c0 = count_o;
    idle(1);
    chk(count_o == c0 + 1, "R2 step", count_o, c0 + 1);

    dma_auto = 1'b1;
    for (int i = 0; i < 140; i++) begin
      drive(1'b1, 1'b1);
      idle($urandom_range(2, 9));
      drive(1'b0, 1'b0);
      idle($urandom_range(2, 19));
    end
    idle(8);
    chk(n_xfer == 140, "R5 transfers rising", n_xfer, 140);
    chk(dma_index == IDX_W'(140 % DEPTH), "R6 wrapped slot", dma_index, 140 % DEPTH);
    chk(n_half == 1 && n_full == 1, "R7 pulse count", {n_half, n_full}, 2);

    cfg_falling = 1'b1;
    idle(2);
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1'b0);
      idle(6);
      chk(!dma_req, "R4 rising ignored in falling mode", dma_req, 0);
      drive(1'b0, 1'b1);
      idle($urandom_range(3, 12));
    end
    idle(8);
    chk(n_xfer == 160, "R4 transfers falling", n_xfer, 160);

    dma_auto = 1'b0;
    idle(2);
    drive(1'b1, 1'b0);
    idle(4);
    drive(1'b0, 1'b1);
    idle(6);
    chk(dma_req && !ovr_flag, "R5 request held", {dma_req, ovr_flag}, 2);
    drive(1'b1, 1'b0);
    idle(4);
    drive(1'b0, 1'b1);
    c2 = exp_val[n_exp-1];
    idle(6);
    chk(ovr_flag, "R8 overcapture set", ovr_flag, 1);
    chk(dma_data == c2, "R8 newer kept", dma_data, c2);
    idle(3);
    chk(ovr_flag, "R8 sticky", ovr_flag, 1);
    ovr_clr = 1'b1;
    idle(1);
    ovr_clr = 1'b0;
    idle(1);
    chk(!ovr_flag, "R8 cleared", ovr_flag, 0);
    man_ack = 1'b1;
    idle(1);
    man_ack = 1'b0;
    idle(1);
    chk(!dma_req, "R5 request dropped on ack", dma_req, 0);
    chk(dma_index == IDX_W'(161 % DEPTH), "R6 single step", dma_index, 161 % DEPTH);

    cfg_enable = 1'b0;
    idle(1);
    c0 = count_o;
    drive(1'b1, 1'b0);
    idle(5);
    drive(1'b0, 1'b0);
    idle(6);
    chk(!dma_req, "R9 no capture when disabled", dma_req, 0);
    chk(count_o == c0, "R2 hold when disabled", count_o, c0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule